// File: doc/BRIEF.md
# Flash Status Ready Poller

This block waits for a page-buffered serial flash to become ready. A one-cycle `start` pulse begins a polling sequence. Each poll is one chip-select frame in SPI mode 0. The frame sends the status-read opcode and clocks in one status byte. A device may be sent this opcode even while it is busy.

If the ready bit of the captured byte is clear, the block keeps select high for a fixed retry interval and then polls again. The sequence ends when one of two things happens:
- a ready byte arrives, or
- a busy byte arrives after the overall timeout budget has run out.

At the end, a one-cycle `done` pulse is given. `timed_out` says which of the two endings occurred. The last byte captured is held, together with three decoded flags:
- compare mismatch,
- binary page-size mode,
- no device present.

The retry interval and the timeout are counted in clock cycles. The defaults are about 3 ms and 2 s at 125 MHz, and simulation can use small values.

Top module: `flash_ready_poller`

## Requirements
- R1: After reset, `flash_cs_n` is 1, `flash_sclk` is 0, `done` is 0, `timed_out` is 0 and `status_byte` is 0x00.
- R2: Each poll is one frame. `flash_cs_n` goes low, then 16 rising edges of `flash_sclk` occur (SPI mode 0: data sampled on the rising edge, changed on the falling edge, MSB first), then `flash_cs_n` goes high. On `flash_mosi` the first 8 bits carry the opcode 0xD7. `flash_sclk` stays low while `flash_cs_n` is high.
- R3: A captured byte with bit 7 = 1 (ready) ends the sequence. `done` is high for exactly one cycle, `timed_out` is 0, and `status_byte` equals the byte clocked in on `flash_miso` in the last frame. The number of frames equals the number of busy replies plus one.
- R4: A captured byte with bit 7 = 0 (busy), before the budget is used up, holds `flash_cs_n` high for exactly RETRY_CYCLES+1 clock cycles before the next frame begins.
- R5: A busy byte captured once TIMEOUT_CYCLES clocks have elapsed since `start` ends the sequence with `done` and `timed_out` = 1. Timeout is never reported earlier than TIMEOUT_CYCLES cycles after `start`.
- R6: `cmp_mismatch` equals bit 6 of `status_byte`.
- R7: `pow2_page` equals bit 0 of `status_byte`.
- R8: `no_device` is 1 exactly when `status_byte` is 0x00 or 0xFF.
- R9: A new `start` after a timed-out sequence clears `timed_out` and begins a fresh budget.
- R10: A `start` pulse during a sequence is ignored: the sequence in progress runs unchanged, and no extra frame is issued after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a polling sequence |
| flash_miso | input | 1 | Serial data from the flash |
| flash_cs_n | output | 1 | Active-low chip select, one frame per poll |
| flash_sclk | output | 1 | Serial clock, idles low |
| flash_mosi | output | 1 | Serial data to the flash |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| timed_out | output | 1 | Sequence ended on the timeout budget |
| status_byte | output | 8 | Last status byte captured |
| cmp_mismatch | output | 1 | Status bit 6: buffer and page compare differed |
| pow2_page | output | 1 | Status bit 0: binary page-size mode |
| no_device | output | 1 | Status read as 0x00 or 0xFF |

## Verification
Each result has a known due point:
- `status_byte` and its decoded flags are valid on the cycle that `done` pulses.
- `done` itself follows the rising edge of `flash_cs_n` by one clock.
- The next frame starts RETRY_CYCLES+1 cycles after that rising edge.

The bench samples on falling clock edges. It waits for `done` and reads every result in that cycle. It checks on the following cycle that `done` has dropped. A behavioural flash model counts frames and serial edges and checks the opcode and the select gaps by timestamps, so frame shape and pacing are checked without reading any internal state.

// File: rtl/frp_pkg.sv
// Package: shared constants, state type and status decode helpers for the
// flash ready poller. Assumes an 8-bit status byte, MSB first on the wire.
package frp_pkg;

    localparam logic [7:0] STATUS_READ_OP = 8'hD7;
    localparam int         RDY_BIT        = 7;
    localparam int         MISMATCH_BIT   = 6;
    localparam int         BINPAGE_BIT    = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_RSP,
        ST_EVAL,
        ST_WAIT
    } poll_state_t;

    // True when the byte looks like a floating or shorted data line
    function automatic logic looks_absent(input logic [7:0] b);
        return (b == 8'h00) || (b == 8'hFF);
    endfunction

endpackage

// File: rtl/frp_byte_shifter.sv
// Byte shifter: moves one byte out on mosi and one byte in from miso in
// SPI mode 0. sclk idles low. Each sclk half period lasts HALF_PERIOD clocks.
// Assumes go is only raised while the shifter is idle.
module frp_byte_shifter #(
    parameter int HALF_PERIOD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       xfer_done,
    output logic       active
);
    localparam int DW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(HALF_PERIOD - 1);

    logic [DW-1:0] div_q;
    logic [2:0]    bit_idx;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;

    assign mosi    = tx_sh[7];
    assign rx_byte = rx_sh;

    // Paces sclk, samples on the rising edge and shifts on the falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            sclk      <= 1'b0;
            div_q     <= '0;
            bit_idx   <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            xfer_done <= 1'b0;
        end else begin
            xfer_done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active  <= 1'b1;
                    tx_sh   <= tx_byte;
                    bit_idx <= '0;
                    div_q   <= '0;
                    sclk    <= 1'b0;
                end
            end else if (div_q == DIV_LAST) begin
                div_q <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[6:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_idx == 3'd7) begin
                        active    <= 1'b0;
                        xfer_done <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 3'd1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + DW'(1);
            end
        end
    end

    AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !sclk && !active) else $error("shifter ended with sclk high"); // R2

endmodule

// File: rtl/frp_poll_ctrl.sv
// Poll controller: runs the poll / evaluate / wait loop. It owns chip select,
// the retry pacing counter and the overall budget counter.
// Assumes RETRY_CYCLES >= 1 and that the shifter answers each go with one
// xfer_done pulse.
module frp_poll_ctrl
    import frp_pkg::*;
#(
    parameter int RETRY_CYCLES   = 375_000,
    parameter int TIMEOUT_CYCLES = 250_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       xfer_done,
    input  logic [7:0] rx_byte,
    output logic       go,
    output logic [7:0] tx_byte,
    output logic       cs_n,
    output logic       done,
    output logic       timed_out,
    output logic [7:0] status
);
    localparam int RW = (RETRY_CYCLES > 1) ? $clog2(RETRY_CYCLES) : 1;
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [RW-1:0] RETRY_LAST = RW'(RETRY_CYCLES - 1);
    localparam logic [TW-1:0] BUDGET     = TW'(TIMEOUT_CYCLES);

    poll_state_t   state;
    logic [RW-1:0] wait_q;
    logic [TW-1:0] elapsed;

    // Saturating count of cycles since start; frozen at the budget
    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed <= '0;
        else if (state == ST_IDLE)
            elapsed <= '0;
        else if (elapsed != BUDGET)
            elapsed <= elapsed + TW'(1);
    end

    // Sequencer: frames, decision on each status byte, retry pacing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cs_n      <= 1'b1;
            go        <= 1'b0;
            tx_byte   <= '0;
            done      <= 1'b0;
            timed_out <= 1'b0;
            status    <= '0;
            wait_q    <= '0;
        end else begin
            go   <= 1'b0;
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    timed_out <= 1'b0;
                    cs_n      <= 1'b0;
                    go        <= 1'b1;
                    tx_byte   <= STATUS_READ_OP;
                    state     <= ST_OPC;
                end
                ST_OPC: if (xfer_done) begin
                    go      <= 1'b1;
                    tx_byte <= 8'h00;
                    state   <= ST_RSP;
                end
                ST_RSP: if (xfer_done) begin
                    cs_n   <= 1'b1;
                    status <= rx_byte;
                    state  <= ST_EVAL;
                end
                ST_EVAL: begin
                    if (status[RDY_BIT]) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (elapsed == BUDGET) begin
                        done      <= 1'b1;
                        timed_out <= 1'b1;
                        state     <= ST_IDLE;
                    end else begin
                        wait_q <= '0;
                        state  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wait_q == RETRY_LAST) begin
                        cs_n    <= 1'b0;
                        go      <= 1'b1;
                        tx_byte <= STATUS_READ_OP;
                        state   <= ST_OPC;
                    end else begin
                        wait_q <= wait_q + RW'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R3
    AST_READY_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[RDY_BIT]) |-> !timed_out) else $error("ready byte flagged timeout"); // R3
    AST_TIMEOUT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timed_out) |-> (elapsed == BUDGET)) else $error("early timeout"); // R5
    AST_WAIT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> cs_n) else $error("select low during retry wait"); // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> !timed_out && !cs_n) else $error("start did not restart"); // R9

endmodule

// File: rtl/flash_ready_poller.sv
// Top: ties the poll controller to the byte shifter and decodes the held
// status byte into ready-independent flags.
// Assumes one flash device on a dedicated select line.
module flash_ready_poller
    import frp_pkg::*;
#(
    parameter int RETRY_CYCLES   = 375_000,
    parameter int TIMEOUT_CYCLES = 250_000_000,
    parameter int HALF_PERIOD    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       flash_miso,
    output logic       flash_cs_n,
    output logic       flash_sclk,
    output logic       flash_mosi,
    output logic       done,
    output logic       timed_out,
    output logic [7:0] status_byte,
    output logic       cmp_mismatch,
    output logic       pow2_page,
    output logic       no_device
);
    logic       go;
    logic [7:0] tx_byte;
    logic [7:0] rx_byte;
    logic       xfer_done;
    logic       sh_active;

    frp_poll_ctrl #(
        .RETRY_CYCLES  (RETRY_CYCLES),
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .xfer_done(xfer_done),
        .rx_byte  (rx_byte),
        .go       (go),
        .tx_byte  (tx_byte),
        .cs_n     (flash_cs_n),
        .done     (done),
        .timed_out(timed_out),
        .status   (status_byte)
    );

    frp_byte_shifter #(
        .HALF_PERIOD(HALF_PERIOD)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .tx_byte  (tx_byte),
        .miso     (flash_miso),
        .sclk     (flash_sclk),
        .mosi     (flash_mosi),
        .rx_byte  (rx_byte),
        .xfer_done(xfer_done),
        .active   (sh_active)
    );

    // Flag decode from the held status byte
    always_comb begin
        cmp_mismatch = status_byte[MISMATCH_BIT];
        pow2_page    = status_byte[BINPAGE_BIT];
        no_device    = looks_absent(status_byte);
    end

    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> !flash_sclk) else $error("sclk high outside frame"); // R2
    AST_SHIFT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sh_active |-> !flash_cs_n) else $error("shifting with select high"); // R2

endmodule

// File: tb/sim_flash_ready_poller.sv
module sim_flash_ready_poller;
    localparam int RETRY   = 20;
    localparam int TMO     = 600;
    localparam int HALF    = 2;
    localparam realtime TCK = 8.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic miso = 1'b0;
    logic cs_n, sclk, mosi, done, timed_out, cmp_mismatch, pow2_page, no_device;
    logic [7:0] status_byte;

    always #4 clk = ~clk;

    flash_ready_poller #(.RETRY_CYCLES(RETRY), .TIMEOUT_CYCLES(TMO), .HALF_PERIOD(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .flash_miso(miso),
        .flash_cs_n(cs_n), .flash_sclk(sclk), .flash_mosi(mosi), .done(done),
        .timed_out(timed_out), .status_byte(status_byte), .cmp_mismatch(cmp_mismatch),
        .pow2_page(pow2_page), .no_device(no_device));

    int checks = 0;
    int fails = 0;

    // Behavioural flash model state
    bit         armed = 0;
    int         busy_polls = 0;
    logic [7:0] busy_byte = 8'h3C;
    logic [7:0] final_byte = 8'h80;
    logic [7:0] resp = 8'h00;
    logic [7:0] opc_sh = 8'h00;
    int         frame_cnt = 0;
    int         rise_cnt = 0;
    int         fall_cnt = 0;
    int         bad_opc = 0;
    int         bad_len = 0;
    int         bad_gap = 0;
    realtime    t_up = 0;

    always @(negedge cs_n) if (armed) begin
        if (frame_cnt > 0 && (($realtime - t_up) / TCK) != RETRY + 1) bad_gap++;
        rise_cnt = 0;
        fall_cnt = 0;
        resp = (frame_cnt < busy_polls) ? busy_byte : final_byte;
        miso = 1'b0;
    end
    always @(posedge sclk) if (armed && !cs_n) begin
        if (rise_cnt < 8) opc_sh = {opc_sh[6:0], mosi};
        rise_cnt++;
    end
    always @(negedge sclk) if (armed && !cs_n) begin
        fall_cnt++;
        if (fall_cnt >= 8 && fall_cnt <= 15) miso = resp[15 - fall_cnt];
    end
    always @(posedge cs_n) if (armed) begin
        frame_cnt++;
        if (opc_sh != 8'hD7) bad_opc++;
        if (rise_cnt != 16) bad_len++;
        t_up = $realtime;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Run one sequence; returns cycles from start to done (or -1)
    task automatic run(input int nbusy, input logic [7:0] bb, input logic [7:0] fb,
                       input bit extra_start, output int cyc);
        busy_polls = nbusy; busy_byte = bb; final_byte = fb;
        frame_cnt = 0; bad_opc = 0; bad_len = 0; bad_gap = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1;
        while (!done && cyc < 5000) begin
            if (extra_start && cyc == 30) start = 1'b1;
            else start = 1'b0;
            @(negedge clk); cyc++;
        end
        start = 1'b0;
        if (!done) cyc = -1;
    endtask

    typedef struct packed { logic [7:0] nbusy; logic [7:0] fin; } vec_t;
    localparam vec_t VECS [5] = '{
        '{8'd0, 8'h80}, '{8'd1, 8'hC1}, '{8'd3, 8'h81}, '{8'd2, 8'hFF}, '{8'd0, 8'hBC}};

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cs_n", cs_n, 1); check("R1 sclk", sclk, 0);
        check("R1 done", done, 0); check("R1 timed_out", timed_out, 0);
        check("R1 status", status_byte, 8'h00);
        rst_n = 1'b1;
        @(negedge clk); armed = 1;

        foreach (VECS[i]) begin
            run(int'(VECS[i].nbusy), 8'h3C, VECS[i].fin, 0, cyc);
            check("R3 done seen", cyc > 0, 1);
            check("R3 timed_out", timed_out, 0);
            check("R3 status", status_byte, VECS[i].fin);
            check("R3 frames", frame_cnt, int'(VECS[i].nbusy) + 1);
            check("R2 opcode", bad_opc, 0);
            check("R2 frame len", bad_len, 0);
            check("R4 gap", bad_gap, 0);
            check("R6 mismatch", cmp_mismatch, VECS[i].fin[6]);
            check("R7 pow2", pow2_page, VECS[i].fin[0]);
            check("R8 no_device", no_device, (VECS[i].fin == 8'hFF) ? 1 : 0);
            @(negedge clk);
            check("R3 done one cycle", done, 0);
            repeat (5) @(negedge clk);
        end

        // R5 timeout with an always-busy all-zero reply (R8 absent device)
        run(1000, 8'h00, 8'h00, 0, cyc);
        check("R5 done seen", cyc > 0, 1);
        check("R5 timed_out", timed_out, 1);
        check("R5 not early", cyc >= TMO, 1);
        check("R5 several polls", frame_cnt > 1, 1);
        check("R4 gap busy run", bad_gap, 0);
        check("R8 zero byte absent", no_device, 1);
        check("R6 zero mismatch", cmp_mismatch, 0);
        repeat (5) @(negedge clk);

        // R9 restart clears timeout
        run(0, 8'h3C, 8'h80, 0, cyc);
        check("R9 timed_out cleared", timed_out, 0);
        check("R9 status", status_byte, 8'h80);
        repeat (5) @(negedge clk);

        // R10 start during a sequence ignored
        run(1, 8'h3C, 8'h81, 1, cyc);
        check("R10 frames", frame_cnt, 2);
        check("R10 status", status_byte, 8'h81);
        repeat (300) @(negedge clk);
        check("R10 no extra frame", frame_cnt, 2);
        check("R10 idle select", cs_n, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule